// File: doc/BRIEF.md
# Multiply-Divide-Accumulate Unit

This block is a small byte-addressed arithmetic engine. A host loads a mode byte and two 16-bit operands one byte at a time through a write port. Writing the upper byte of the second operand launches the operation. Signed multiplication and accumulation finish at that write's clock edge. Division runs for several cycles in a shift-subtract divider, and `busy` is high while it does.

There are three modes. Multiplication stores the signed 32-bit product, sign-extended to 40 bits. Division treats the first operand as a signed dividend and the second as an unsigned divisor. It always yields a non-negative remainder, and it packs the remainder above the quotient. Accumulation adds the signed product into a running 40-bit sum and raises an overflow flag whenever that add reaches 2^40. The 40-bit result and the flag are read back one byte at a time through a combinational read port.

Top module: `muldiv_acc_unit`

## Requirements
- R1: After reset the result is 0, the overflow flag is 0, `busy` is 0, both operands are 0 and the mode is multiplication.
- R2: A write to address 0 sets the mode from data bits [1:0] (0 multiply, 1 divide, 2 or 3 accumulate). If data bit 1 is set, the 40-bit result reads 0 from the next cycle.
- R3: In multiply mode, the write to address 4 makes the result equal to the signed product of both operands, sign-extended to 40 bits, from the next cycle. The overflow flag is not changed.
- R4: In divide mode with a nonzero divisor, the result becomes {remainder[15:0], quotient[15:0]} with bits 39:32 zero. The remainder lies in 0 to divisor-1 and the quotient is (dividend - remainder)/divisor, truncated to 16 bits.
- R5: Division by a zero divisor yields a result of 0.
- R6: A division started at a clock edge keeps `busy` high for the next 17 cycles. The result changes at the edge where `busy` falls, and it holds its previous value while `busy` is high.
- R7: Every write accepted while `busy` is high is ignored.
- R8: In accumulate mode, the write to address 4 adds the signed product to the result modulo 2^40. The overflow flag is set to 1 if the unbounded sum is at least 2^40 or below 0, and to 0 otherwise.
- R9: Mode code 3 behaves exactly like mode code 2.
- R10: The second operand becomes 0 after every operation. The first operand also becomes 0 after a division and keeps its value after the other modes.
- R11: Read addresses 0 to 4 return result bytes from least to most significant. Address 5 returns the overflow flag in bit 7 with the other bits 0. Addresses 6 and 7 return 0.
- R12: Addresses 1 and 2 write the low and high bytes of the first operand, and address 3 writes the low byte of the second. Each write changes only its own byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Write address: 0 mode, 1/2 first operand lo/hi, 3/4 second operand lo/hi |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read address: 0-4 result bytes, 5 status |
| rd_data | output | 8 | Read data selected by rd_addr (combinational) |
| busy | output | 1 | High while a division is in progress |

## Verification
A wrong operand register does not show at once. It shows only in the result of the next operation, which appears at the result bytes one cycle after the launching write, or 18 cycles later for a division. For this reason the stimulus also launches operations after partial operand writes, so that left-over or wrongly cleared bytes become visible. A wrong divider step count or a wrong correction for negative dividends shows as a `busy` pulse of the wrong length, or as a wrong remainder or quotient at the edge where `busy` falls. A wrong carry in the accumulator shows in the status byte on the cycle after the add.

// File: rtl/madu_pkg.sv
package madu_pkg;
  localparam int OPW  = 16;
  localparam int ACCW = 40;
  localparam int PRW  = 2 * OPW;

  typedef enum logic [1:0] {
    MODE_MUL  = 2'd0,
    MODE_DIV  = 2'd1,
    MODE_ACC  = 2'd2,
    MODE_ACC3 = 2'd3
  } mode_e;

  localparam int WA_MODE = 0;
  localparam int WA_A_LO = 1;
  localparam int WA_A_HI = 2;
  localparam int WA_B_LO = 3;
  localparam int WA_B_HI = 4;

  function automatic logic [PRW-1:0] smul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic signed [PRW-1:0] p;
    p = PRW'($signed(a)) * PRW'($signed(b));
    return p;
  endfunction

  function automatic logic [ACCW-1:0] sext_prod(input logic [PRW-1:0] p);
    return {{(ACCW-PRW){p[PRW-1]}}, p};
  endfunction

  // returns {carry_or_borrow, new_sum}
  function automatic logic [ACCW:0] acc_add(input logic [ACCW-1:0] sum, input logic [PRW-1:0] p);
    return {1'b0, sum} + {{(ACCW+1-PRW){p[PRW-1]}}, p};
  endfunction

  // corrects an unsigned magnitude division for a negative dividend
  function automatic logic [PRW-1:0] div_fix(input logic neg, input logic [OPW-1:0] q0,
                                             input logic [OPW-1:0] r0, input logic [OPW-1:0] d);
    logic [OPW-1:0] q, r;
    if (!neg || r0 == '0) begin
      q = neg ? (~q0 + 1'b1) : q0;
      r = r0;
    end else begin
      q = ~q0;
      r = d - r0;
    end
    if (d == '0) return '0;
    return {r, q};
  endfunction
endpackage

// File: rtl/madu_opregs.sv
module madu_opregs
  import madu_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           blocked,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [7:0]     wr_data,
  output mode_e          mode,
  output logic [OPW-1:0] opnd_a,
  output logic [OPW-1:0] opnd_b,
  output logic           start,
  output logic           clr_acc
);
  logic [OPW-1:0] a_q, b_q;
  mode_e          mode_q;
  logic           wr_ok;

  assign wr_ok   = wr_en && !blocked;
  assign start   = wr_ok && (wr_addr == AW'(WA_B_HI));
  assign clr_acc = wr_ok && (wr_addr == AW'(WA_MODE)) && wr_data[1];
  assign mode    = mode_q;
  assign opnd_a  = a_q;
  assign opnd_b  = {wr_data, b_q[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= MODE_MUL;
    end else if (wr_ok) begin
      case (wr_addr)
        AW'(WA_MODE): mode_q   <= mode_e'(wr_data[1:0]);
        AW'(WA_A_LO): a_q[7:0] <= wr_data;
        AW'(WA_A_HI): a_q[15:8] <= wr_data;
        AW'(WA_B_LO): b_q[7:0] <= wr_data;
        AW'(WA_B_HI): begin
          b_q <= '0;
          if (mode_q == MODE_DIV) a_q <= '0;
        end
        default: ;
      endcase
    end
  end

  a_r10_b_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (b_q == '0));
  a_r10_a_cleared_div: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_q == MODE_DIV) |=> (a_q == '0));
  a_r10_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_q != MODE_DIV) |=> $stable(a_q));
  a_r7_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> ($stable(a_q) && $stable(b_q) && $stable(mode_q)));
endmodule

// File: rtl/madu_divider.sv
module madu_divider
  import madu_pkg::*;
#(
  parameter int W = OPW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         running,
  output logic         done,
  output logic [2*W-1:0] quo_rem
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W:0]   rem_q;
  logic [W-1:0] quo_q, dvs_q;
  logic         neg_q, run_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]   trial;
  logic         ge;

  assign trial = {rem_q[W-1:0], quo_q[W-1]};
  assign ge    = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      neg_q  <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !run_q) begin
        rem_q <= '0;
        quo_q <= dividend[W-1] ? (~dividend + 1'b1) : dividend;
        dvs_q <= divisor;
        neg_q <= dividend[W-1];
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        rem_q <= ge ? (trial - {1'b0, dvs_q}) : trial;
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign running = run_q;
  assign done    = done_q;
  assign quo_rem = div_fix(neg_q, quo_q, rem_q[W-1:0], dvs_q);

  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dvs_q != '0) |-> (quo_rem[2*W-1:W] < dvs_q));
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q || done_q) |-> !start);
  a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> done_q);
endmodule

// File: rtl/madu_result.sv
module madu_result
  import madu_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  mode_e          mode,
  input  logic [OPW-1:0] opnd_a,
  input  logic [OPW-1:0] opnd_b,
  input  logic           clr_acc,
  input  logic           div_running,
  input  logic           div_done,
  input  logic [PRW-1:0] div_res,
  input  logic [AW-1:0]  rd_addr,
  output logic [7:0]     rd_data
);
  localparam int NB      = ACCW / 8;
  localparam int STAT_AD = NB;

  logic [ACCW-1:0] acc_q;
  logic            ovf_q;
  logic [PRW-1:0]  prod;
  logic [ACCW:0]   acc_next;
  logic            acc_op, mul_op;
  logic [7:0]      res_byte [NB];

  assign prod     = smul(opnd_a, opnd_b);
  assign acc_next = acc_add(acc_q, prod);
  assign mul_op   = start && (mode == MODE_MUL);
  assign acc_op   = start && (mode == MODE_ACC || mode == MODE_ACC3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_acc) begin
      acc_q <= '0;
    end else if (div_done) begin
      acc_q <= {{(ACCW-PRW){1'b0}}, div_res};
    end else if (mul_op) begin
      acc_q <= sext_prod(prod);
    end else if (acc_op) begin
      acc_q <= acc_next[ACCW-1:0];
      ovf_q <= acc_next[ACCW];
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign res_byte[g] = acc_q[g*8 +: 8];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NB; i++)
      if (rd_addr == i[AW-1:0]) rd_data = res_byte[i];
    if (rd_addr == AW'(STAT_AD)) rd_data = {ovf_q, 7'b0};
  end

  a_r8_ovf_only_on_acc: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_op |=> $stable(ovf_q));
  a_r6_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    div_running |=> $stable(acc_q));
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> (acc_q == '0));
  a_r3_mul_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    mul_op |=> ((acc_q[ACCW-1:PRW-1] == '0) || (&acc_q[ACCW-1:PRW-1])));
  a_r4_div_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> (acc_q[ACCW-1:PRW] == '0));
endmodule

// File: rtl/muldiv_acc_unit.sv
module muldiv_acc_unit
  import madu_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy
);
  mode_e          mode;
  logic [OPW-1:0] opnd_a, opnd_b;
  logic           start, clr_acc;
  logic           div_running, div_done, div_start;
  logic [PRW-1:0] div_res;

  assign busy      = div_running || div_done;
  assign div_start = start && (mode == MODE_DIV);

  madu_opregs #(.AW(AW)) u_opregs (
    .clk(clk), .rst_n(rst_n), .blocked(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .start(start), .clr_acc(clr_acc)
  );

  madu_divider #(.W(OPW)) u_divider (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(opnd_a), .divisor(opnd_b),
    .running(div_running), .done(div_done), .quo_rem(div_res)
  );

  madu_result #(.AW(AW)) u_result (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .clr_acc(clr_acc),
    .div_running(div_running), .div_done(div_done), .div_res(div_res),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  a_r6_busy_rises_on_div: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |=> busy);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(div_start));
endmodule

// File: tb/test_muldiv_acc_unit.sv
module test_muldiv_acc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done_run = 0;

  // reference model state
  logic [15:0] m_a, m_b;
  logic [1:0]  m_mode;
  logic [39:0] m_res, m_pend;
  logic        m_ovf;
  int          m_cnt;

  muldiv_acc_unit i_muldiv_acc_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  always #10 clk = ~clk;

  function automatic longint sprod(logic [15:0] a, logic [15:0] b);
    longint x, y;
    x = $signed(a);
    y = $signed(b);
    return x * y;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 0; m_b = 0; m_mode = 0; m_res = 0; m_ovf = 0; m_cnt = 0; m_pend = 0;
    end else begin
      automatic bit blk = (m_cnt > 0);
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_res = m_pend;
      end
      if (!blk && wr_en) begin
        case (wr_addr)
          3'd0: begin m_mode = wr_data[1:0]; if (wr_data[1]) m_res = 0; end
          3'd1: m_a[7:0] = wr_data;
          3'd2: m_a[15:8] = wr_data;
          3'd3: m_b[7:0] = wr_data;
          3'd4: begin
            automatic logic [15:0] b = {wr_data, m_b[7:0]};
            automatic longint p = sprod(m_a, b);
            if (m_mode == 2'd0) begin
              m_res = p[39:0];
            end else if (m_mode == 2'd1) begin
              automatic int dv = $signed(m_a);
              automatic int d = b;
              if (d == 0) m_pend = 0;
              else begin
                automatic int r = dv % d;
                automatic int q;
                if (r < 0) r += d;
                q = (dv - r) / d;
                m_pend = {8'h00, r[15:0], q[15:0]};
              end
              m_cnt = 17;
              m_a = 0;
            end else begin
              automatic longint t = longint'(m_res) + p;
              m_ovf = (t < 0) || (t >= (64'sd1 <<< 40));
              m_res = t[39:0];
            end
            m_b = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      for (int k = 0; k < 8; k++) begin
        automatic logic [7:0] exp;
        rd_addr = k[2:0];
        #1;
        exp = (k < 5) ? m_res[k*8 +: 8] : (k == 5) ? {m_ovf, 7'b0} : 8'h00;
        checks++;
        if (rd_data !== exp) begin
          errors++;
          $display("FAIL %s R11 byte %0d actual %02h expected %02h at cycle %0d",
                   cur_req, k, rd_data, exp, cycles);
        end
      end
      checks++;
      if (busy !== (m_cnt > 0)) begin
        errors++;
        $display("FAIL %s R6 busy actual %0b expected %0b at cycle %0d",
                 cur_req, busy, (m_cnt > 0), cycles);
      end
    end
  end

  task automatic finish_run();
    done_run = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_run) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a[2:0];
    wr_data = d[7:0];
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic op(input int mode, input int a, input int b);
    wr(0, mode);
    wr(1, a & 8'hff); wr(2, (a >> 8) & 8'hff);
    wr(3, b & 8'hff); wr(4, (b >> 8) & 8'hff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(3);

    cur_req = "R3";
    op(0, 16'hFFFD, 7); idle(2);
    op(0, 16'h7FFF, 16'h7FFF); idle(2);
    op(0, 16'h8000, 16'h8000); idle(2);
    op(0, 16'h8000, 16'h7FFF); idle(2);

    cur_req = "R10"; // only second operand upper byte rewritten: first operand kept
    wr(4, 8'h01); idle(2);
    cur_req = "R12";
    wr(1, 8'h05); wr(3, 8'h03); wr(4, 8'h00); idle(2);

    cur_req = "R4";
    op(1, 16'hFFF9, 2); idle(20);
    op(1, 100, 7); idle(20);
    op(1, 16'h8000, 16'hFFFF); idle(20);
    op(1, 16'hFFFA, 3); idle(20);
    op(1, 16'h7FFF, 1); idle(20);

    cur_req = "R7";
    op(1, 1000, 9);
    wr(0, 2); wr(1, 8'h77); wr(3, 8'h44); wr(4, 8'h22); idle(20);

    cur_req = "R10"; // first operand cleared after division
    wr(0, 0); wr(3, 8'h09); wr(4, 8'h00); idle(2);

    cur_req = "R5";
    op(1, 1234, 0); idle(20);
    op(1, 16'h8000, 0); idle(20);

    cur_req = "R2";
    op(0, 300, 300); idle(2);
    wr(0, 2); idle(2);
    op(0, 300, 300); idle(2);
    wr(0, 1); idle(2);

    cur_req = "R8";
    op(2, 16'hFFFF, 1); idle(2);
    op(2, 5, 5); idle(2);
    op(2, 16'h7FFF, 16'h7FFF); idle(2);
    wr(0, 2);
    wr(1, 8'h00); wr(2, 8'h80);
    for (int i = 0; i < 1030; i++) begin
      wr(3, 8'h00); wr(4, 8'h80);
    end
    idle(2);
    op(2, 16'h8000, 16'h7FFF); idle(2);

    cur_req = "R9";
    op(3, 16'hFFFE, 3); idle(2);
    op(3, 40, 16'hFFF0); idle(2);
    wr(0, 3); idle(2);
    op(3, 16'h1234, 16'h0567); idle(2);

    cur_req = "R11";
    op(0, 16'hFF00, 16'h0101); idle(3);

    finish_run();
  end
endmodule